// File: doc/BRIEF.md
# Registered Command/Address Buffer with Parity Check

This block sits between a memory controller and a rank of DRAM devices. Each rising clock edge it captures the chip-select, bank, address, row/column strobe, write-enable, clock-enable and termination-enable lines. It drives them unchanged to the devices until the next edge. Every command therefore reaches the devices exactly one clock later than the controller issued it.

The controller also supplies one parity bit with each command. The buffer registers that bit together with its command. For valid commands only, it checks even parity over the address lines and the three command strobes. A mismatch pulls a shared, open-drain error line low. The line is modelled as a pull-down enable. It is stretched over two cycles, and a run of bad commands keeps it low for longer. An asynchronous active-low reset forces every registered output low, clock-enable included, so the devices stay idle, and it clears any pending error.

Top module: `cmd_regbuf`

## Requirements
- R1: Every command field (chip select, bank, address, three strobes, clock enable, termination enable) present at the inputs before a rising edge appears unchanged at the outputs right after that edge and holds until the next edge.
- R2: A command is in error when the XOR of the address bits, the three strobe lines and the parity input is 1 (even parity). Bank, chip select, clock enable and termination enable are not covered.
- R3: Parity is judged only for commands whose registered chip select is 0. A deselect (chip select 1) with wrong parity never raises the error output.
- R4: For an erroneous command captured at edge N, the error output becomes active right after edge N+1, one cycle after that command appears at the outputs.
- R5: The error output stays active for two cycles per erroneous command. Erroneous commands on consecutive cycles extend it until two cycles after the last one.
- R6: The error output `err_pull_low` is 1 when the open-drain error line must be pulled low and 0 when the line is released.
- R7: While reset is low, all registered outputs, including clock enable and chip select, are 0 at once, without waiting for a clock edge.
- R8: Reset releases the error output and clears any pending error, so no error appears after reset ends unless a new erroneous command arrives.
- R9: Forwarding does not depend on parity: a command with wrong or absent parity is passed to the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_cs_n | input | 1 | Chip select from controller, active low |
| in_ba | input | 3 | Bank address from controller |
| in_addr | input | 16 | Row/column address from controller |
| in_ras_n | input | 1 | Row strobe, active low |
| in_cas_n | input | 1 | Column strobe, active low |
| in_we_n | input | 1 | Write enable, active low |
| in_cke | input | 1 | Clock enable for devices |
| in_odt | input | 1 | Termination enable for devices |
| in_par | input | 1 | Even parity bit over address and strobes |
| out_cs_n | output | 1 | Registered chip select |
| out_ba | output | 3 | Registered bank address |
| out_addr | output | 16 | Registered address |
| out_ras_n | output | 1 | Registered row strobe |
| out_cas_n | output | 1 | Registered column strobe |
| out_we_n | output | 1 | Registered write enable |
| out_cke | output | 1 | Registered clock enable |
| out_odt | output | 1 | Registered termination enable |
| err_pull_low | output | 1 | 1 = pull error line low, 0 = release |

## Verification
Assertions check on every cycle that the outputs equal the previous cycle's inputs, that all outputs are zero whenever reset is low, that a detected mismatch activates the error output on the next edge, that the error output never rises without a preceding mismatch, and that the stretch counter stays within its hold length. The exact two-cycle stretch length, the extension by back-to-back errors, the exclusion of deselects and of the bank, clock-enable and termination lines from parity, and the clearing of a pending error by reset depend on command sequences. Only the bench's scenarios, scored against a model of expected outputs, show these.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;
  parameter int CB_ADDR_W = 16;
  parameter int CB_BA_W   = 3;

  typedef struct packed {
    logic                 cs_n;
    logic [CB_BA_W-1:0]   ba;
    logic [CB_ADDR_W-1:0] addr;
    logic                 ras_n;
    logic                 cas_n;
    logic                 we_n;
    logic                 cke;
    logic                 odt;
  } cab_t;

  // 1 when the covered lines plus parity bit hold an odd number of ones
  function automatic logic odd_count(input logic [CB_ADDR_W-1:0] a,
                                     input logic ras_n, input logic cas_n,
                                     input logic we_n, input logic par);
    return ^{a, ras_n, cas_n, we_n, par};
  endfunction
endpackage

// File: rtl/cab_pipe.sv
module cab_pipe
  import cmdbuf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cab_t d,
  input  logic par_d,
  output cab_t q,
  output logic par_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q     <= '0;
      par_q <= 1'b0;
    end else begin
      q     <= d;
      par_q <= par_d;
    end
  end
endmodule

// File: rtl/par_check.sv
module par_check
  import cmdbuf_pkg::*;
(
  input  logic                 cs_n_q,
  input  logic [CB_ADDR_W-1:0] addr_q,
  input  logic                 ras_n_q,
  input  logic                 cas_n_q,
  input  logic                 we_n_q,
  input  logic                 par_q,
  output logic                 mism
);
  logic odd;
  always_comb begin
    odd  = odd_count(addr_q, ras_n_q, cas_n_q, we_n_q, par_q);
    mism = odd && !cs_n_q;
  end
endmodule

// File: rtl/err_stretch.sv
module err_stretch #(
  parameter int HOLD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mism,
  output logic err_on
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] LOAD = CW'(HOLD);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (mism)       cnt <= LOAD;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign err_on = (cnt != '0);

  AST_ERR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    mism |=> err_on); // R4
  AST_ERR_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_on) |-> $past(mism)); // R4
  AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LOAD); // R5
endmodule

// File: rtl/cmd_regbuf.sv
module cmd_regbuf
  import cmdbuf_pkg::*;
#(
  parameter int ADDR_W   = CB_ADDR_W,
  parameter int BA_W     = CB_BA_W,
  parameter int HOLD_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_cs_n,
  input  logic [BA_W-1:0]   in_ba,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_ras_n,
  input  logic              in_cas_n,
  input  logic              in_we_n,
  input  logic              in_cke,
  input  logic              in_odt,
  input  logic              in_par,
  output logic              out_cs_n,
  output logic [BA_W-1:0]   out_ba,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_ras_n,
  output logic              out_cas_n,
  output logic              out_we_n,
  output logic              out_cke,
  output logic              out_odt,
  output logic              err_pull_low
);
  localparam int CMD_W = $bits(cab_t);

  cab_t cmd_d, cmd_q;
  logic par_q, mism_w, err_w;
  logic up_q;

  always_comb begin
    cmd_d.cs_n  = in_cs_n;
    cmd_d.ba    = in_ba;
    cmd_d.addr  = in_addr;
    cmd_d.ras_n = in_ras_n;
    cmd_d.cas_n = in_cas_n;
    cmd_d.we_n  = in_we_n;
    cmd_d.cke   = in_cke;
    cmd_d.odt   = in_odt;
  end

  cab_pipe u_pipe (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (cmd_d),
    .par_d (in_par),
    .q     (cmd_q),
    .par_q (par_q)
  );

  par_check u_chk (
    .cs_n_q  (cmd_q.cs_n),
    .addr_q  (cmd_q.addr),
    .ras_n_q (cmd_q.ras_n),
    .cas_n_q (cmd_q.cas_n),
    .we_n_q  (cmd_q.we_n),
    .par_q   (par_q),
    .mism    (mism_w)
  );

  err_stretch #(.HOLD(HOLD_CYC)) u_err (
    .clk    (clk),
    .rst_n  (rst_n),
    .mism   (mism_w),
    .err_on (err_w)
  );

  assign out_cs_n     = cmd_q.cs_n;
  assign out_ba       = cmd_q.ba;
  assign out_addr     = cmd_q.addr;
  assign out_ras_n    = cmd_q.ras_n;
  assign out_cas_n    = cmd_q.cas_n;
  assign out_we_n     = cmd_q.we_n;
  assign out_cke      = cmd_q.cke;
  assign out_odt      = cmd_q.odt;
  assign err_pull_low = err_w;

  // marks that at least one edge has passed with reset high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up_q <= 1'b0;
    else        up_q <= 1'b1;
  end

  AST_PIPE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    up_q |-> ({out_cs_n, out_ba, out_addr, out_ras_n, out_cas_n, out_we_n,
               out_cke, out_odt} ==
              $past({in_cs_n, in_ba, in_addr, in_ras_n, in_cas_n, in_we_n,
                     in_cke, in_odt}))); // R1
  AST_RESET_LOW: assert property (@(posedge clk)
    !rst_n |-> ({out_cs_n, out_ba, out_addr, out_ras_n, out_cas_n, out_we_n,
                 out_cke, out_odt} == CMD_W'(0)) && !err_pull_low); // R7
endmodule

// File: tb/sim_cmd_regbuf.sv
module sim_cmd_regbuf;
  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic in_cs_n = 1'b1, in_ras_n = 1'b1, in_cas_n = 1'b1, in_we_n = 1'b1;
  logic in_cke = 1'b0, in_odt = 1'b0, in_par = 1'b0;
  logic [2:0]  in_ba = '0;
  logic [15:0] in_addr = '0;
  logic out_cs_n, out_ras_n, out_cas_n, out_we_n, out_cke, out_odt, err_pull_low;
  logic [2:0]  out_ba;
  logic [15:0] out_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [24:0] cmd;
    logic        err;
    string       tag;
  } exp_t;
  exp_t sb[$];
  logic h1 = 1'b0, h2 = 1'b0;

  always #10 clk = ~clk;

  cmd_regbuf u0 (
    .clk(clk), .rst_n(rst_n), .in_cs_n(in_cs_n), .in_ba(in_ba), .in_addr(in_addr),
    .in_ras_n(in_ras_n), .in_cas_n(in_cas_n), .in_we_n(in_we_n), .in_cke(in_cke),
    .in_odt(in_odt), .in_par(in_par), .out_cs_n(out_cs_n), .out_ba(out_ba),
    .out_addr(out_addr), .out_ras_n(out_ras_n), .out_cas_n(out_cas_n),
    .out_we_n(out_we_n), .out_cke(out_cke), .out_odt(out_odt),
    .err_pull_low(err_pull_low)
  );

  function automatic logic [24:0] outs_now();
    return {out_cs_n, out_ba, out_addr, out_ras_n, out_cas_n, out_we_n, out_cke, out_odt};
  endfunction

  task automatic check1(input string tag, input logic [24:0] act, input logic [24:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: one command per cycle; parity computed here by counting ones
  task automatic drive(input logic cs_n, input logic [2:0] ba, input logic [15:0] a,
                       input logic ras, input logic cas, input logic we,
                       input logic cke, input logic odt, input logic bad, input string tag);
    exp_t it;
    logic par;
    logic e;
    @(negedge clk); #1;
    par = ($countones({a, ras, cas, we}) % 2 == 1) ? 1'b1 : 1'b0;
    par = par ^ bad;
    in_cs_n = cs_n; in_ba = ba; in_addr = a; in_ras_n = ras; in_cas_n = cas;
    in_we_n = we; in_cke = cke; in_odt = odt; in_par = par;
    e = bad && !cs_n;
    it.cmd = {cs_n, ba, a, ras, cas, we, cke, odt};
    it.err = h1 | h2;
    it.tag = tag;
    sb.push_back(it);
    h2 = h1;
    h1 = e;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b1, 3'd0, 16'h0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R1");
  endtask

  // monitor: pops one expected item per cycle
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t it;
      it = sb.pop_front();
      check1(it.tag, outs_now(), it.cmd);
      check1({it.tag, " err R6"}, {24'd0, err_pull_low}, {24'd0, it.err});
    end
  end

  task automatic do_reset(input bit nonzero_inputs);
    @(negedge clk); #1;
    if (nonzero_inputs) begin
      in_cs_n = 1'b1; in_ba = 3'h7; in_addr = 16'hFFFF; in_ras_n = 1'b1;
      in_cas_n = 1'b1; in_we_n = 1'b1; in_cke = 1'b1; in_odt = 1'b1; in_par = 1'b1;
    end
    rst_n = 1'b0;
    #1;
    check1("R7 outputs low in reset", outs_now(), 25'd0);
    check1("R8 error released in reset", {24'd0, err_pull_low}, 25'd0);
    sb.delete();
    h1 = 1'b0; h2 = 1'b0;
    repeat (2) @(negedge clk);
    #2;
    check1("R7 outputs held low", outs_now(), 25'd0);
    rst_n = 1'b1;
  endtask

  initial begin
    #1 rst_n = 1'b0;
    #40;
    check1("R7 reset state", outs_now(), 25'd0);
    check1("R8 reset err", {24'd0, err_pull_low}, 25'd0);
    @(negedge clk); #2 rst_n = 1'b1;

    // R1: varied valid commands with correct parity
    drive(1'b0, 3'd1, 16'h1234, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R1 act");
    drive(1'b0, 3'd5, 16'hA5A5, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R1 rd");
    drive(1'b0, 3'd7, 16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R1 wr");
    drive(1'b1, 3'd2, 16'h0001, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R1 desel");
    idle(3);

    // R4 R5 R9: single bad-parity command, forwarded, two-cycle flag
    drive(1'b0, 3'd3, 16'h0F0F, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R9 bad fwd");
    drive(1'b1, 3'd0, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R4 flag rises");
    drive(1'b1, 3'd0, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R5 flag second");
    drive(1'b1, 3'd0, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R5 flag released");
    idle(2);

    // R3: deselect with wrong parity raises nothing
    drive(1'b1, 3'd4, 16'h8001, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R3 desel bad");
    idle(4);

    // R2: bank/cke/odt not covered; parity from address and strobes only
    drive(1'b0, 3'd6, 16'h00FF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R2 ba cke odt");
    drive(1'b0, 3'd1, 16'h7001, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R2 mix");
    idle(4);

    // R5: back-to-back errors extend the flag
    drive(1'b0, 3'd0, 16'h0003, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R5 b2b first");
    drive(1'b0, 3'd0, 16'h0007, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R5 b2b second");
    drive(1'b0, 3'd0, 16'h000F, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R5 b2b third");
    idle(5);

    // R9: parity input stuck low (unconnected) still forwards
    for (int i = 0; i < 4; i++) begin
      logic [15:0] a;
      a = 16'h1111 * 16'(i + 1);
      drive(1'b1, 3'(i), a, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1,
            ($countones({a, 1'b0, 1'b1, 1'b0}) % 2 == 1), "R9 par stuck");
    end
    idle(2);

    // R8: reset while an error flag is active clears it
    drive(1'b0, 3'd2, 16'h0101, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R8 setup bad");
    drive(1'b1, 3'd0, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R8 flag on");
    @(negedge clk); #1;
    check1("R8 flag active before reset", {24'd0, err_pull_low}, 25'd1);
    do_reset(1'b1);
    drive(1'b0, 3'd1, 16'h0200, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R8 after reset");
    idle(4);

    // R7: reset with no clock edge forces outputs low immediately
    do_reset(1'b1);
    idle(3);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule